// File: doc/BRIEF.md
# Per-core tick timer bank

This block holds one local event timer for each processor core. Every timer counts down in two stages. A prescaler divides the input clock by a programmable ratio and gives one tick for each full period. An event counter counts those ticks and, when it runs out, latches a pending flag. When that flag is enabled, it drives the core's interrupt line.

Software reaches each timer through its own 256-byte window on a 32-bit register port. A new event count is written into a buffer together with a load-request flag. The running counter takes the buffered value on the next tick. In one-shot use the event stage stops itself after it fires. In periodic use it reloads from the buffer and keeps firing until software clears its run bit. Each timer also has a write-acknowledge register: a bit sets for each configuration write that has taken effect, and software clears it by writing 1.

The register port is a plain control port and has no back-pressure. A request is taken in the cycle that `bus_sel` is high. A read answers exactly one cycle later on `bus_rvalid`/`bus_rdata`, and no request is ever refused.

Top module: `core_tick_bank`

## Requirements
- R1: After reset every register of every timer reads 0, no tick or event count is running, and every `irq` bit is low.
- R2: Timer n answers in address window 0x300 + 0x100*n. Within a window the offsets are 0x00 tick divisor, 0x08 event count buffer, 0x20 control, 0x30 event status, 0x34 event enable and 0x40 write acknowledge. A read of any other window or offset returns 0, and a write there changes no register.
- R3: While control bit 0 is 1, the prescaler gives one tick every (divisor + 1) clock cycles. A divisor of 0 gives one tick per cycle.
- R4: A write to offset 0x08 stores bits 30:0 as the buffered count. When bit 31 of that write is 1, a load is requested: bit 31 reads back as 1 until the next tick copies the buffer into the event counter. That tick does not also count down.
- R5: While control bit 1 is 1, each tick lowers the event count by one. The tick that arrives with a count of 1 or 0 expires the counter and sets event status bit 0. A loaded count N therefore expires on the Nth tick after the load.
- R6: With control bit 2 set, an expiry reloads the event counter from the buffer and control keeps its value. With bit 2 clear, an expiry clears control bit 1 in hardware and no further events follow.
- R7: While control bit 0 is 0 the prescaler holds its count. While control bit 1 is 0 the event counter holds its count. After a restart, counting continues from the held values.
- R8: Writing 1 to event status bit 0 clears it. An expiry in the same cycle wins. `irq[n]` is 1 exactly when timer n's status bit 0 and enable bit 0 are both 1.
- R9: Write-acknowledge bit 0 sets after a divisor write, bit 1 after an event count buffer write and bit 3 after a control write. Writing 1 to a bit clears it, and bit 2 always reads 0.
- R10: A read request gives `bus_rvalid` = 1 with the data on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| irq | output | NUM_CORES | Per-timer event interrupt |

## Verification
The bench builds the bank with two timers, a 12-bit address and full 32-bit and 31-bit counter widths. With two timers it can show that the windows are decoded apart and that writes to the empty window just above the bank and to the window just below it are dropped. Small divisor and count values (0, 1, 2, 3, 4) bring many expiries into a short run. That makes room to cover the periodic reload, the one-shot self-stop, freeze and resume, and a load request that lands on a tick, all while a behavioural model is compared with the design on every cycle.

// File: rtl/ltick_pkg.sv
package ltick_pkg;

  // register offsets inside one timer window
  localparam logic [7:0] OFF_DIV    = 8'h00;
  localparam logic [7:0] OFF_CNTBUF = 8'h08;
  localparam logic [7:0] OFF_CTRL   = 8'h20;
  localparam logic [7:0] OFF_STAT   = 8'h30;
  localparam logic [7:0] OFF_EN     = 8'h34;
  localparam logic [7:0] OFF_ACK    = 8'h40;

  // write-acknowledge bit positions
  localparam int ACK_DIV    = 0;
  localparam int ACK_CNTBUF = 1;
  localparam int ACK_CTRL   = 3;

  // load-request flag in the count buffer write
  localparam int LOAD_REQ_BIT = 31;

  typedef struct packed {
    logic periodic;   // bit 2
    logic evt_run;    // bit 1
    logic tick_run;   // bit 0
  } ltick_ctrl_t;

endpackage

// File: rtl/ltick_prescaler.sv
module ltick_prescaler #(
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TICK_W-1:0] divisor,
  output logic              tick
);

  logic [TICK_W-1:0] cnt_q;

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= divisor;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  // R7: stopped prescaler holds its count
  p_hold_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));

  // R3: a tick restarts the period from the divisor
  p_reload_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(divisor)));

endmodule

// File: rtl/ltick_evtcnt.sv
module ltick_evtcnt #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             periodic,
  input  logic [CNT_W-1:0] buf_val,
  input  logic             load_req,
  output logic             load_pend,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q <= CNT_W'(1));
  assign expire = tick && !load_pend && run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend <= 1'b0;
    end else if (load_req) begin
      load_pend <= 1'b1;
    end else if (tick) begin
      load_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      if (load_pend) begin
        cnt_q <= buf_val;
      end else if (run) begin
        if (at_end) cnt_q <= periodic ? buf_val : '0;
        else        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R4: a pending load lands on the tick
  p_load_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && load_pend) |=> (cnt_q == $past(buf_val)));

  // R7: stopped event stage holds unless a load lands
  p_hold_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(tick && load_pend)) |=> $stable(cnt_q));

endmodule

// File: rtl/ltick_unit.sv
module ltick_unit
  import ltick_pkg::*;
#(
  parameter int TICK_W = 32,
  parameter int CNT_W  = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [7:0]  off,
  input  logic [31:0] wdata,
  output logic [31:0] rd_data,
  output logic        irq
);

  logic [TICK_W-1:0] div_q;
  logic [CNT_W-1:0]  cntbuf_q;
  ltick_ctrl_t       ctrl_q;
  logic              stat_q;
  logic              en_q;
  logic [3:0]        ack_q;

  logic wr_div, wr_cntbuf, wr_ctrl, wr_stat, wr_en, wr_ack;
  logic tick, expire, load_pend;

  assign wr_div    = sel && wr && (off == OFF_DIV);
  assign wr_cntbuf = sel && wr && (off == OFF_CNTBUF);
  assign wr_ctrl   = sel && wr && (off == OFF_CTRL);
  assign wr_stat   = sel && wr && (off == OFF_STAT);
  assign wr_en     = sel && wr && (off == OFF_EN);
  assign wr_ack    = sel && wr && (off == OFF_ACK);

  ltick_prescaler #(.TICK_W(TICK_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.tick_run),
    .divisor (div_q),
    .tick    (tick)
  );

  ltick_evtcnt #(.CNT_W(CNT_W)) u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (ctrl_q.evt_run),
    .periodic  (ctrl_q.periodic),
    .buf_val   (cntbuf_q),
    .load_req  (wr_cntbuf && wdata[LOAD_REQ_BIT]),
    .load_pend (load_pend),
    .expire    (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      cntbuf_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (wr_div)    div_q    <= wdata[TICK_W-1:0];
      if (wr_cntbuf) cntbuf_q <= wdata[CNT_W-1:0];
      if (wr_en)     en_q     <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ltick_ctrl_t'(wdata[2:0]);
    end else if (expire && !ctrl_q.periodic) begin
      ctrl_q.evt_run <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (expire) begin
      stat_q <= 1'b1;
    end else if (wr_stat && wdata[0]) begin
      stat_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= '0;
    end else begin
      ack_q <= (wr_ack ? (ack_q & ~wdata[3:0]) : ack_q)
             | {wr_ctrl, 1'b0, wr_cntbuf, wr_div};
    end
  end

  assign irq = stat_q && en_q;

  always_comb begin
    rd_data = '0;
    if (sel && !wr) begin
      unique case (off)
        OFF_DIV:    rd_data[TICK_W-1:0] = div_q;
        OFF_CNTBUF: begin
          rd_data[CNT_W-1:0]      = cntbuf_q;
          rd_data[LOAD_REQ_BIT]   = load_pend;
        end
        OFF_CTRL:   rd_data[2:0] = ctrl_q;
        OFF_STAT:   rd_data[0]   = stat_q;
        OFF_EN:     rd_data[0]   = en_q;
        OFF_ACK:    rd_data[3:0] = ack_q;
        default:    rd_data      = '0;
      endcase
    end
  end

  // R5: expiry latches status
  p_expire_sets_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> stat_q);

  // R6: one-shot expiry stops the event stage
  p_oneshot_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.periodic && !wr_ctrl) |=> !ctrl_q.evt_run);

  // R9: control write acknowledged
  p_ack_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ack_q[ACK_CTRL]);

endmodule

// File: rtl/core_tick_bank.sv
module core_tick_bank #(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 12,
  parameter int BASE_WIN  = 3,
  parameter int TICK_W    = 32,
  parameter int CNT_W     = 31
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 bus_rvalid,
  output logic [31:0]          bus_rdata,
  output logic [NUM_CORES-1:0] irq
);

  localparam int WIN_W = ADDR_W - 8;

  logic [31:0] rd_vec [NUM_CORES];
  logic [31:0] rd_any;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic hit;
    assign hit = bus_sel && (bus_addr[ADDR_W-1:8] == WIN_W'(BASE_WIN + g));

    ltick_unit #(.TICK_W(TICK_W), .CNT_W(CNT_W)) u_unit (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (hit),
      .wr      (bus_wr),
      .off     (bus_addr[7:0]),
      .wdata   (bus_wdata),
      .rd_data (rd_vec[g]),
      .irq     (irq[g])
    );
  end

  always_comb begin
    rd_any = '0;
    for (int i = 0; i < NUM_CORES; i++) rd_any = rd_any | rd_vec[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      bus_rdata  <= rd_any;
    end
  end

  // R10: every read request answered next cycle
  p_read_answered_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> bus_rvalid);

endmodule

// File: tb/tb_core_tick_bank.sv
`timescale 1ns/1ps
module tb_core_tick_bank;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bsel = 1'b0, bwr = 1'b0;
  logic [11:0] baddr = '0;
  logic [31:0] bwd = '0;
  logic brv;
  logic [31:0] brd;
  logic [NC-1:0] irq;

  core_tick_bank #(.NUM_CORES(NC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bsel), .bus_wr(bwr),
    .bus_addr(baddr), .bus_wdata(bwd), .bus_rvalid(brv),
    .bus_rdata(brd), .irq(irq)
  );

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_div [NC], m_pre [NC];
  logic [30:0] m_buf [NC], m_evt [NC];
  logic        m_pend [NC], m_stat [NC], m_en [NC];
  logic [2:0]  m_ctrl [NC];
  logic [3:0]  m_ack [NC];
  logic        m_rv;
  logic [31:0] m_rd;
  logic        hit, w, tk, ex;
  logic [7:0]  off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NC; c++) begin
        m_div[c] = 0; m_pre[c] = 0; m_buf[c] = 0; m_evt[c] = 0;
        m_pend[c] = 0; m_stat[c] = 0; m_en[c] = 0; m_ctrl[c] = 0; m_ack[c] = 0;
      end
      m_rv = 0; m_rd = 0;
    end else begin
      m_rv = bsel && !bwr;
      m_rd = 0;
      off = baddr[7:0];
      for (int c = 0; c < NC; c++) begin
        hit = bsel && (baddr[11:8] == 4'(3 + c));
        w = hit && bwr;
        if (hit && !bwr) begin
          case (off)
            8'h00: m_rd = m_div[c];
            8'h08: m_rd = {m_pend[c], m_buf[c]};
            8'h20: m_rd = {29'd0, m_ctrl[c]};
            8'h30: m_rd = {31'd0, m_stat[c]};
            8'h34: m_rd = {31'd0, m_en[c]};
            8'h40: m_rd = {28'd0, m_ack[c]};
            default: m_rd = 0;
          endcase
        end
        tk = m_ctrl[c][0] && (m_pre[c] == 0);
        ex = 0;
        if (tk) begin
          if (m_pend[c]) m_evt[c] = m_buf[c];
          else if (m_ctrl[c][1]) begin
            if (m_evt[c] <= 1) begin
              ex = 1;
              m_evt[c] = m_ctrl[c][2] ? m_buf[c] : 31'd0;
            end else m_evt[c] = m_evt[c] - 1;
          end
        end
        if (m_ctrl[c][0]) m_pre[c] = (m_pre[c] == 0) ? m_div[c] : m_pre[c] - 1;
        if (w && off == 8'h08 && bwd[31]) m_pend[c] = 1;
        else if (tk) m_pend[c] = 0;
        if (w && off == 8'h20) m_ctrl[c] = bwd[2:0];
        else if (ex && !m_ctrl[c][2]) m_ctrl[c][1] = 0;
        if (ex) m_stat[c] = 1;
        else if (w && off == 8'h30 && bwd[0]) m_stat[c] = 0;
        if (w && off == 8'h34) m_en[c] = bwd[0];
        if (w && off == 8'h00) m_div[c] = bwd;
        if (w && off == 8'h08) m_buf[c] = bwd[30:0];
        if (w && off == 8'h40) m_ack[c] = m_ack[c] & ~(bwd[3:0] & 4'b1011);
        if (w && off == 8'h00) m_ack[c][0] = 1;
        if (w && off == 8'h08) m_ack[c][1] = 1;
        if (w && off == 8'h20) m_ack[c][3] = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NC; c++)
        chk(irq[c] === (m_stat[c] && m_en[c]), "R3 R5 R6 R7 R8 model irq",
            32'(irq[c]), 32'(m_stat[c] && m_en[c]));
      chk(brv === m_rv, "R10 model rvalid", 32'(brv), 32'(m_rv));
      if (m_rv) chk(brd === m_rd, "R2 R4 R9 model rdata", brd, m_rd);
    end
  end

  function automatic logic [11:0] ad(input int c, input logic [7:0] o);
    return 12'(((3 + c) << 8) | o);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bsel = 1; bwr = 1; baddr = a; bwd = d;
    @(negedge clk); bsel = 0; bwr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bsel = 1; bwr = 0; baddr = a;
    @(negedge clk); bsel = 0;
    chk(brv === 1'b1, "R10 read answered", 32'(brv), 32'd1);
    d = brd;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d === e, tag, d, e);
  endtask

  task automatic wait_irq(input int c, input int max, output int t);
    t = -1;
    for (int i = 0; i < max; i++) begin
      @(negedge clk);
      if (irq[c]) begin t = cyc; break; end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int c = 0; c < NC; c++) begin
      rd_chk(ad(c, 8'h00), 0, "R1 divisor");
      rd_chk(ad(c, 8'h08), 0, "R1 count buffer");
      rd_chk(ad(c, 8'h20), 0, "R1 control");
      rd_chk(ad(c, 8'h30), 0, "R1 status");
      rd_chk(ad(c, 8'h34), 0, "R1 enable");
      rd_chk(ad(c, 8'h40), 0, "R1 ack");
    end
    chk(irq === '0, "R1 irq", 32'(irq), 0);

    // R9 divisor acknowledge and clear
    wr(ad(0, 8'h00), 1);
    rd_chk(ad(0, 8'h40), 32'h1, "R9 divisor ack");
    wr(ad(0, 8'h40), 32'h1);
    rd_chk(ad(0, 8'h40), 32'h0, "R9 ack cleared");

    // R4 load request, R3 R5 R6 periodic timing
    wr(ad(0, 8'h08), 32'h8000_0003);
    rd_chk(ad(0, 8'h08), 32'h8000_0003, "R4 pending flag");
    wr(ad(0, 8'h34), 1);
    wr(ad(0, 8'h20), 32'h7);
    wait_irq(0, 60, t0);
    chk(t0 != -1, "R5 first expiry", 32'(t0), 1);
    wr(ad(0, 8'h30), 1);
    wait_irq(0, 20, t1);
    chk(t1 - t0 == 6, "R3 R5 period cycles", 32'(t1 - t0), 6);
    rd_chk(ad(0, 8'h08), 32'h3, "R4 load taken");
    rd_chk(ad(0, 8'h20), 32'h7, "R6 periodic keeps control");

    // R7 freeze and resume
    wr(ad(0, 8'h20), 0);
    wr(ad(0, 8'h30), 1);
    repeat (30) @(negedge clk);
    chk(irq[0] === 1'b0, "R7 frozen no event", 32'(irq[0]), 0);
    wr(ad(0, 8'h20), 32'h7);
    wait_irq(0, 20, t0);
    chk(t0 != -1, "R7 resumed event", 32'(t0), 1);
    wr(ad(0, 8'h20), 0);
    wr(ad(0, 8'h30), 1);

    // R6 one-shot on timer 1, divisor 0
    wr(ad(1, 8'h00), 0);
    wr(ad(1, 8'h08), 32'h8000_0004);
    wr(ad(1, 8'h34), 1);
    wr(ad(1, 8'h20), 32'h3);
    repeat (20) @(negedge clk);
    chk(irq[1] === 1'b1, "R5 one-shot expiry", 32'(irq[1]), 1);
    rd_chk(ad(1, 8'h20), 32'h1, "R6 one-shot clears bit 1");
    rd_chk(ad(1, 8'h40), 32'hB, "R9 ack bits 0 1 3");
    wr(ad(1, 8'h40), 32'hB);
    rd_chk(ad(1, 8'h40), 32'h0, "R9 ack w1c");
    wr(ad(1, 8'h30), 1);
    repeat (20) @(negedge clk);
    chk(irq[1] === 1'b0, "R6 no event after one-shot", 32'(irq[1]), 0);
    rd_chk(ad(1, 8'h30), 32'h0, "R8 status cleared");

    // R8 enable gating
    wr(ad(1, 8'h34), 0);
    wr(ad(1, 8'h08), 32'h8000_0002);
    wr(ad(1, 8'h20), 32'h3);
    repeat (15) @(negedge clk);
    chk(irq[1] === 1'b0, "R8 masked irq", 32'(irq[1]), 0);
    rd_chk(ad(1, 8'h30), 32'h1, "R8 status while masked");
    wr(ad(1, 8'h34), 1);
    chk(irq[1] === 1'b1, "R8 enabled irq", 32'(irq[1]), 1);
    wr(ad(1, 8'h30), 1);
    chk(irq[1] === 1'b0, "R8 w1c drops irq", 32'(irq[1]), 0);

    // R2 unmapped windows and offsets
    wr(12'h220, 32'h7);
    wr(12'h520, 32'h7);
    wr(ad(0, 8'h10), 32'hFFFF);
    rd_chk(12'h520, 0, "R2 empty window read");
    rd_chk(ad(0, 8'h10), 0, "R2 unmapped offset");
    rd_chk(ad(0, 8'h20), 0, "R2 timer 0 untouched");
    rd_chk(ad(1, 8'h20), 32'h1, "R2 timer 1 untouched");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule